// File: doc/BRIEF.md
# Four-Beat Burst Bus Slave with Register-File Memory

This block is a memory-mapped slave on a synchronous bus in which the address and the data use separate cycles. A master opens each transaction with a one-cycle start strobe. In that cycle the master presents the word address, the direction and an optional burst request. The slave then answers every data beat with an acknowledge. A burst moves four 32-bit words from a single address cycle. The beats step through the aligned four-word group that holds the starting word and wrap within it.

A configuration input lets the slave refuse bursts. When it does, the slave raises a burst-inhibit flag in the cycle after the start strobe and completes only one beat, so the master has to fall back to single transfers. A second configuration input sets a number of wait cycles that come before every beat. A value of zero gives one word per cycle. While the master still expects further words, it holds a data-in-progress input high. When that input is low on an acknowledged beat, the burst ends there.

Top module: `burst_slave_top`

## Requirements
- R1: A start strobe is taken only while the slave is idle. Direction, word address and burst request are captured in that cycle alone, and changes to them or further strobes during the data phase have no effect.
- R2: Acknowledge is never high in the cycle of an accepted start strobe, so a single-beat transaction spans at least two cycles.
- R3: A burst request that is not inhibited completes at most four acknowledged beats.
- R4: Beat k of a burst that starts at word index i uses the word index whose bits [1:0] are (i+k) mod 4 and whose upper bits equal those of i.
- R5: Each beat is preceded by exactly wait_cfg cycles with acknowledge low, counted from the cycle after the start strobe or the cycle after the previous beat.
- R6: With wait_cfg at zero, acknowledge is high in the cycle after the start strobe and on every following cycle until the last beat.
- R7: A beat acknowledged while more_beats is low is the last one. Acknowledge is low in the next cycle and the slave is idle again.
- R8: If inhibit_cfg is high at an accepted start strobe, burst_inhibit is high for exactly the next cycle and the transaction completes one beat. Otherwise burst_inhibit stays low.
- R9: A write stores wdata to the current word in the acknowledged cycle. A read drives the current word on rdata in the acknowledged cycle, and rdata is zero in every other cycle.
- R10: During and after reset, ack and burst_inhibit are low and the slave is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start | input | 1 | Start strobe that marks the address cycle |
| addr | input | IDX_W (6) | Word address of the first beat |
| wr_en | input | 1 | Direction, 1 = write, 0 = read |
| burst_req | input | 1 | Master asks for a four-beat burst |
| more_beats | input | 1 | Master still expects another beat after this one |
| wdata | input | 32 | Write data for the acknowledged beat |
| inhibit_cfg | input | 1 | Refuse bursts when high |
| wait_cfg | input | WAIT_W (4) | Wait cycles inserted before each beat |
| rdata | output | 32 | Read data, valid when xfer_ack is high |
| xfer_ack | output | 1 | Beat acknowledge |
| burst_inhibit | output | 1 | Burst refused, one-cycle flag after the start strobe |

## Verification
The bound checker watches the cycle-level rules on every clock edge: no acknowledge in the start cycle, the one-cycle burst-inhibit flag, the four-beat cap, a single beat under inhibition, the return to idle after a last beat, and the spacing of beats for zero and non-zero wait counts. The bench scenarios are needed for properties that involve stored data or an order of addresses. These are the wrap order inside the aligned group, the data written and read back, the fact that late changes to the address and direction have no effect, and the fact that an inhibited burst write leaves the neighbouring words untouched.

// File: rtl/burst_slave_pkg.sv
package burst_slave_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } seq_state_t;

  localparam int BURST_BEATS = 4;

  // next beat position inside the aligned four-word group
  function automatic logic [1:0] wrap_step(input logic [1:0] low);
    return low + 2'd1;
  endfunction

  // a beat closes the transaction when it is single, fourth, or the master stops
  function automatic logic beat_is_last(input logic burst,
                                        input logic [1:0] done,
                                        input logic more);
    return (!burst) || (done == 2'(BURST_BEATS - 1)) || (!more);
  endfunction

endpackage

// File: rtl/bs_wait_timer.sv
module bs_wait_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              expired
);

  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/bs_regfile.sv
module bs_regfile #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/bs_sequencer.sv
module bs_sequencer
  import burst_slave_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic [IDX_W-1:0] addr_idx,
  input  logic             wr_en,
  input  logic             burst_req,
  input  logic             more_beats,
  input  logic             inhibit_cfg,
  input  logic             wait_zero,
  output logic             accept,
  output logic             timer_load,
  output logic             busy,
  output logic             beat_fire,
  output logic             last_beat,
  output logic             is_write,
  output logic [IDX_W-1:0] cur_idx,
  output logic [1:0]       beat_num,
  output logic             inhibit_flag
);

  seq_state_t state;
  logic       is_burst;

  assign busy       = (state == ST_DATA);
  assign accept     = xfer_start && (state == ST_IDLE);
  assign beat_fire  = busy && wait_zero;
  assign last_beat  = beat_is_last(is_burst, beat_num, more_beats);
  assign timer_load = accept || (beat_fire && !last_beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cur_idx      <= '0;
      is_write     <= 1'b0;
      is_burst     <= 1'b0;
      beat_num     <= '0;
      inhibit_flag <= 1'b0;
    end else begin
      inhibit_flag <= accept && inhibit_cfg;
      if (accept) begin
        state    <= ST_DATA;
        cur_idx  <= addr_idx;
        is_write <= wr_en;
        is_burst <= burst_req && !inhibit_cfg;
        beat_num <= '0;
      end else if (beat_fire) begin
        if (last_beat) begin
          state <= ST_IDLE;
        end else begin
          cur_idx  <= {cur_idx[IDX_W-1:2], wrap_step(cur_idx[1:0])};
          beat_num <= beat_num + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/burst_slave_top.sv
module burst_slave_top #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic [IDX_W-1:0]  addr,
  input  logic              wr_en,
  input  logic              burst_req,
  input  logic              more_beats,
  input  logic [DATA_W-1:0] wdata,
  input  logic              inhibit_cfg,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic [DATA_W-1:0] rdata,
  output logic              xfer_ack,
  output logic              burst_inhibit
);

  logic              accept;
  logic              timer_load;
  logic              wait_zero;
  logic              busy;
  logic              beat_fire;
  logic              last_beat;
  logic              is_write;
  logic [IDX_W-1:0]  cur_idx;
  logic [1:0]        beat_num;
  logic [DATA_W-1:0] mem_rdata;

  bs_sequencer #(.IDX_W(IDX_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_start   (xfer_start),
    .addr_idx     (addr),
    .wr_en        (wr_en),
    .burst_req    (burst_req),
    .more_beats   (more_beats),
    .inhibit_cfg  (inhibit_cfg),
    .wait_zero    (wait_zero),
    .accept       (accept),
    .timer_load   (timer_load),
    .busy         (busy),
    .beat_fire    (beat_fire),
    .last_beat    (last_beat),
    .is_write     (is_write),
    .cur_idx      (cur_idx),
    .beat_num     (beat_num),
    .inhibit_flag (burst_inhibit)
  );

  bs_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (wait_cfg),
    .expired  (wait_zero)
  );

  bs_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (beat_fire && is_write),
    .idx   (cur_idx),
    .wdata (wdata),
    .rdata (mem_rdata)
  );

  assign xfer_ack = beat_fire;
  assign rdata    = (beat_fire && !is_write) ? mem_rdata : '0;

endmodule

// File: rtl/burst_slave_checker.sv
module burst_slave_checker #(
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_start,
  input logic              inhibit_cfg,
  input logic [WAIT_W-1:0] wait_cfg,
  input logic              xfer_ack,
  input logic              burst_inhibit,
  input logic              accept,
  input logic              busy,
  input logic              last_beat
);

  logic [2:0] ack_cnt;
  logic       inh_txn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_cnt <= '0;
      inh_txn <= 1'b0;
    end else if (accept) begin
      ack_cnt <= '0;
      inh_txn <= inhibit_cfg;
    end else if (xfer_ack) begin
      ack_cnt <= ack_cnt + 3'd1;
    end
  end

  AST_MIDSTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && busy && !(xfer_ack && last_beat)) |=> busy); // R1
  AST_NO_ACK_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !xfer_ack); // R2
  AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> (ack_cnt < 3'd4)); // R3
  AST_WAIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && !last_beat && (wait_cfg != '0)) |=> !xfer_ack); // R5
  AST_FIRST_BEAT_NOWAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (wait_cfg == '0)) |=> xfer_ack); // R6
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && !last_beat && (wait_cfg == '0)) |=> xfer_ack); // R6
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && last_beat) |=> (!busy && !xfer_ack)); // R7
  AST_INHIBIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && inhibit_cfg) |=> burst_inhibit); // R8
  AST_INHIBIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_inhibit |=> !burst_inhibit); // R8
  AST_INHIBIT_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && inh_txn) |-> (ack_cnt == 3'd0)); // R8
  AST_ACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> busy); // R10

endmodule

bind burst_slave_top burst_slave_checker #(.WAIT_W(WAIT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .xfer_start    (xfer_start),
  .inhibit_cfg   (inhibit_cfg),
  .wait_cfg      (wait_cfg),
  .xfer_ack      (xfer_ack),
  .burst_inhibit (burst_inhibit),
  .accept        (accept),
  .busy          (busy),
  .last_beat     (last_beat)
);

// File: tb/burst_slave_top_test.sv
module burst_slave_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        burst_req = 1'b0;
  logic        more_beats = 1'b0;
  logic [31:0] wdata = '0;
  logic        inhibit_cfg = 1'b0;
  logic [3:0]  wait_cfg = '0;
  logic [31:0] rdata;
  logic        xfer_ack;
  logic        burst_inhibit;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] model [64];

  always #2 clk = ~clk;

  burst_slave_top uut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .addr(addr),
    .wr_en(wr_en), .burst_req(burst_req), .more_beats(more_beats),
    .wdata(wdata), .inhibit_cfg(inhibit_cfg), .wait_cfg(wait_cfg),
    .rdata(rdata), .xfer_ack(xfer_ack), .burst_inhibit(burst_inhibit)
  );

  // {wr, burst, inhibit, beats[2:0], wait[3:0], word addr[15:0], seed[31:0]}
  localparam logic [57:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b0, 3'd4, 4'd0, 16'd0,  32'hA000_0000},
    {1'b0, 1'b1, 1'b0, 3'd4, 4'd0, 16'd0,  32'h0000_0000},
    {1'b1, 1'b1, 1'b0, 3'd4, 4'd1, 16'd6,  32'hB100_0011},
    {1'b0, 1'b0, 1'b0, 3'd1, 4'd2, 16'd5,  32'h0000_0000},
    {1'b0, 1'b1, 1'b0, 3'd4, 4'd0, 16'd7,  32'h0000_0000},
    {1'b1, 1'b1, 1'b1, 3'd4, 4'd0, 16'd16, 32'hC0DE_0016},
    {1'b1, 1'b1, 1'b0, 3'd2, 4'd0, 16'd18, 32'hD00D_0018},
    {1'b0, 1'b1, 1'b0, 3'd4, 4'd3, 16'd16, 32'h0000_0000}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input bit wr, input bit bst, input bit inh,
                          input int nb, input int wt, input int a,
                          input logic [31:0] seed, input bit poke, input bit now);
    int base;
    int n;
    int idx;
    logic [31:0] d;
    if (!now) @(negedge clk);
    xfer_start  = 1'b1;
    addr        = a[5:0];
    wr_en       = wr;
    burst_req   = bst;
    inhibit_cfg = inh;
    wait_cfg    = wt[3:0];
    more_beats  = bst && (nb > 1);
    chk("R2", "ack in start cycle", {31'd0, xfer_ack}, 32'd0);
    @(negedge clk);
    xfer_start = 1'b0;
    addr       = ~a[5:0];
    burst_req  = ~bst;
    chk("R8", "inhibit flag after start", {31'd0, burst_inhibit}, {31'd0, inh});
    n    = (bst && !inh) ? nb : 1;
    base = a & 63;
    for (int b = 0; b < n; b++) begin
      idx = (base & ~3) | ((base + b) & 3);
      for (int w = 0; w < wt; w++) begin
        if (poke && w == 0) begin
          xfer_start = 1'b1;
          wr_en      = ~wr;
        end
        chk("R5", "ack low in wait cycle", {31'd0, xfer_ack}, 32'd0);
        @(negedge clk);
        xfer_start = 1'b0;
      end
      more_beats = (b < n - 1);
      d     = seed ^ (32'(b) << 8);
      wdata = d;
      chk("R5 R6", "beat acknowledged", {31'd0, xfer_ack}, 32'd1);
      if (wr) model[idx] = d;
      else chk("R4 R9", "read data", rdata, model[idx]);
      @(negedge clk);
    end
    chk("R7", "ack low after last beat", {31'd0, xfer_ack}, 32'd0);
    chk("R9", "rdata zero when idle", rdata, 32'd0);
    more_beats = 1'b0;
    wr_en      = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "ack in reset", {31'd0, xfer_ack}, 32'd0);
    chk("R10", "inhibit in reset", {31'd0, burst_inhibit}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "ack after reset", {31'd0, xfer_ack}, 32'd0);
    chk("R10", "rdata after reset", rdata, 32'd0);

    // preload every word with single writes (R9)
    for (int i = 0; i < 64; i++)
      run_xfer(1'b1, 1'b0, 1'b0, 1, 0, i, 32'h5A00_0000 + 32'(i) * 32'h0101, 1'b0, 1'b0);

    // table of vectors covering R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < 8; v++)
      run_xfer(VEC[v][57], VEC[v][56], VEC[v][55], int'(VEC[v][54:52]),
               int'(VEC[v][51:48]), int'(VEC[v][47:32]), VEC[v][31:0], 1'b0, 1'b0);

    // R8: inhibited burst write must leave word 17 at its preload value
    run_xfer(1'b0, 1'b0, 1'b0, 1, 0, 17, 32'd0, 1'b0, 1'b0);
    chk("R8", "neighbour of inhibited write kept", model[17], 32'h5A00_0000 + 32'd17 * 32'h0101);

    // R1: strobe and flipped direction during wait cycles are ignored
    run_xfer(1'b0, 1'b1, 1'b0, 4, 2, 9, 32'd0, 1'b1, 1'b0);
    run_xfer(1'b0, 1'b0, 1'b0, 1, 0, 9, 32'd0, 1'b0, 1'b0);

    // R1 R7: start taken in the very cycle after a last beat
    run_xfer(1'b1, 1'b0, 1'b0, 1, 0, 30, 32'hE0E0_0030, 1'b0, 1'b0);
    run_xfer(1'b0, 1'b0, 1'b0, 1, 0, 30, 32'd0, 1'b0, 1'b1);

    // R3: master keeps more_beats high on the fourth beat, still four beats
    @(negedge clk);
    xfer_start = 1'b1; addr = 6'd40; wr_en = 1'b0; burst_req = 1'b1;
    inhibit_cfg = 1'b0; wait_cfg = 4'd0; more_beats = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    for (int b = 0; b < 4; b++) begin
      chk("R3", "burst beat ack", {31'd0, xfer_ack}, 32'd1);
      @(negedge clk);
    end
    chk("R3", "no fifth beat", {31'd0, xfer_ack}, 32'd0);
    more_beats = 1'b0;

    // R10: reset in the middle of a long wait
    @(negedge clk);
    xfer_start = 1'b1; addr = 6'd3; burst_req = 1'b1; wait_cfg = 4'd9; more_beats = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", "inhibit cleared by reset", {31'd0, burst_inhibit}, 32'd0);
    rst_n = 1'b1;
    wait_cfg = 4'd0;
    more_beats = 1'b0;
    repeat (12) begin
      @(negedge clk);
      chk("R10", "no ack after mid-transfer reset", {31'd0, xfer_ack}, 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule